// File: doc/BRIEF.md
# ASID-Tagged Translation Cache with Encoded Flush

This block is a small, fully associative cache of address translations for a device-side memory management unit. Each line holds an address-space identifier (ASID), a 20-bit virtual page number (VPN, the virtual address above its 4 KB page offset), a physical page number (PFN) and three attribute bits: readable, writable and non-secure. A lookup that matches a valid line returns the PFN and attributes in the same cycle. A lookup that matches nothing raises a miss, which an external table walker answers later through the fill port. Fills land in the lines in round-robin order.

Invalidation is controlled by a single 32-bit command word. The word picks one of three scopes: every line, one 4 MB section, or one 16 KB group. It can also limit the flush to a single ASID. A translation configuration register sets how many lines are active and whether hits may be served while a miss is outstanding. A statistics configuration register gates a saturating hit counter and a saturating miss counter, and can clear them.

Top module: `tlb_asid_cache`

## Requirements
- R1: A lookup hits only on a valid line whose ASID and VPN both equal the request and whose index is below the active-line count (translation config bits [4:0]). On a hit, `lkHit` is high in the same cycle, with that line's PFN and attributes on the outputs.
- R2: With no miss outstanding, a lookup that matches no line raises `lkMiss` and marks a miss outstanding. A fill clears the outstanding miss. A filled line is visible to lookups from the next cycle.
- R3: Fills go into line indices 0, 1, 2 and onward. After the last active line, the next fill wraps to index 0, so the oldest fill is the one evicted.
- R4: Writing the flush command (register 0) with bits [1:0] = 0 invalidates every line that passes the ASID filter.
- R5: Flush type 2 invalidates lines whose VPN bits [19:10] equal command bits [19:10] (one 4 MB section).
- R6: Flush type 3 invalidates lines whose VPN bits [19:2] equal command bits [19:2] (one 16 KB group). Type 1 invalidates nothing.
- R7: When command bit 31 is set, a flush touches only lines whose ASID equals command bits [30:29]. When bit 31 is clear, lines of every ASID are touched.
- R8: A flush takes effect on the clock edge that ends its write cycle. A lookup in that write cycle still sees the lines as they were before the flush.
- R9: With hit-under-miss off (translation config bit 29 = 0), every lookup made while a miss is outstanding raises `lkStall` and neither hits nor misses.
- R10: With hit-under-miss on, a lookup that hits while a miss is outstanding is served. A lookup that misses during that time stalls.
- R11: Statistics config (register 2) bit 31 enables counting: each served hit adds one to the hit counter (read address 0), and each raised miss adds one to the miss counter (read address 1). While counting is off, both counters hold their values.
- R12: Writing statistics config bit 30 as 1 and then as 0 clears both counters on the second write.
- R13: A counter at all ones stays at all ones instead of wrapping.
- R14: After reset, the translation config reads 0x20000010, both counters and the statistics config read 0, and no line is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lkValid | input | 1 | Lookup request |
| lkAsid | input | 2 | Lookup ASID |
| lkVpn | input | 20 | Lookup virtual page number |
| lkHit | output | 1 | Lookup served from a line |
| lkMiss | output | 1 | Lookup missed; a miss is now outstanding |
| lkStall | output | 1 | Lookup refused; retry later |
| lkPfn | output | 20 | Physical page number on a hit |
| lkRd | output | 1 | Readable attribute on a hit |
| lkWr | output | 1 | Writable attribute on a hit |
| lkNs | output | 1 | Non-secure attribute on a hit |
| fillValid | input | 1 | Walker fill strobe |
| fillAsid | input | 2 | Fill ASID |
| fillVpn | input | 20 | Fill VPN |
| fillPfn | input | 20 | Fill PFN |
| fillRd | input | 1 | Fill readable attribute |
| fillWr | input | 1 | Fill writable attribute |
| fillNs | input | 1 | Fill non-secure attribute |
| regWe | input | 1 | Register write strobe |
| regWrAddr | input | 2 | Write target: 0 flush command, 1 translation config, 2 statistics config |
| regWrData | input | 32 | Write data |
| regRdAddr | input | 2 | Read select: 0 hit count, 1 miss count, 2 translation config, 3 statistics config |
| regRdData | output | 32 | Read data |

## Verification
The bench builds the block with a 4-bit counter width in place of the default 32 bits. This makes counter saturation reachable in about twenty hits, while the line count, address widths and command layout keep their default values. It also narrows the active-line count to 4 and to 2, which makes the round-robin wrap and the exclusion of lines above the active count visible within a handful of fills. Random lookups, fills, flushes of all four types and configuration changes are compared against a behavioural model of the line array.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int unsigned TLB_ENTRIES = 16;
  parameter int unsigned VPN_W       = 20;
  parameter int unsigned PFN_W       = 20;
  parameter int unsigned ASID_W      = 2;

  localparam int unsigned IDX_W   = $clog2(TLB_ENTRIES);
  localparam int unsigned LINES_W = IDX_W + 1;

  // flush command layout
  localparam int unsigned FL_ASID_EN  = 31;
  localparam int unsigned FL_ASID_LSB = 29;
  localparam int unsigned SEC_LSB     = 10;
  localparam int unsigned GRP_LSB     = 2;
  localparam logic [1:0]  FL_ALL      = 2'd0;
  localparam logic [1:0]  FL_SECTION  = 2'd2;
  localparam logic [1:0]  FL_GROUP    = 2'd3;

  // configuration layout
  localparam int unsigned HUM_BIT       = 29;
  localparam int unsigned STAT_EN_BIT   = 31;
  localparam int unsigned STAT_TEST_BIT = 30;
  localparam logic [31:0] TLB_CFG_RST   = 32'h2000_0010;

  localparam logic [1:0] WA_FLUSH   = 2'd0;
  localparam logic [1:0] WA_TLBCFG  = 2'd1;
  localparam logic [1:0] WA_STATCFG = 2'd2;
  localparam logic [1:0] RA_HIT     = 2'd0;
  localparam logic [1:0] RA_MISS    = 2'd1;
  localparam logic [1:0] RA_TLBCFG  = 2'd2;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ns;
  } pageAttr_t;

  typedef struct packed {
    logic                      fillEn;
    logic [IDX_W-1:0]          fillIdx;
    logic                      flushEn;
    logic [1:0]                flushType;
    logic                      flushAsidEn;
    logic [ASID_W-1:0]         flushAsid;
    logic [VPN_W-1:GRP_LSB]    flushVpn;
    logic [LINES_W-1:0]        activeLines;
  } ctrlStrobe_t;
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
  import tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strobe,
  input  logic [ASID_W-1:0] fillAsid,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [PFN_W-1:0]  fillPfn,
  input  pageAttr_t         fillAttr,
  input  logic [ASID_W-1:0] lkAsid,
  input  logic [VPN_W-1:0]  lkVpn,
  output logic              lookupHit,
  output logic [PFN_W-1:0]  hitPfn,
  output pageAttr_t         hitAttr
);
  logic [TLB_ENTRIES-1:0] validQ;
  logic [TLB_ENTRIES-1:0] matchVec;
  logic [TLB_ENTRIES-1:0] killVec;
  logic [ASID_W-1:0]      asidQ [TLB_ENTRIES];
  logic [VPN_W-1:0]       vpnQ  [TLB_ENTRIES];
  logic [PFN_W-1:0]       pfnQ  [TLB_ENTRIES];
  pageAttr_t              attrQ [TLB_ENTRIES];

  // per-line flush qualification and lookup compare
  always_comb begin
    for (int i = 0; i < TLB_ENTRIES; i++) begin
      logic asidOk;
      logic vaOk;
      asidOk = !strobe.flushAsidEn || (asidQ[i] == strobe.flushAsid);
      case (strobe.flushType)
        FL_ALL:     vaOk = 1'b1;
        FL_SECTION: vaOk = (vpnQ[i][VPN_W-1:SEC_LSB] == strobe.flushVpn[VPN_W-1:SEC_LSB]);
        FL_GROUP:   vaOk = (vpnQ[i][VPN_W-1:GRP_LSB] == strobe.flushVpn);
        default:    vaOk = 1'b0;
      endcase
      killVec[i]  = strobe.flushEn && asidOk && vaOk;
      matchVec[i] = validQ[i] && (LINES_W'(i) < strobe.activeLines) &&
                    (asidQ[i] == lkAsid) && (vpnQ[i] == lkVpn);
    end
  end

  // lowest matching index wins
  always_comb begin
    lookupHit = |matchVec;
    hitPfn    = '0;
    hitAttr   = '0;
    for (int i = TLB_ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        hitPfn  = pfnQ[i];
        hitAttr = attrQ[i];
      end
    end
  end

  // a fill into a line beats a flush of the same line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      validQ <= '0;
    end else begin
      for (int i = 0; i < TLB_ENTRIES; i++) begin
        if (strobe.fillEn && strobe.fillIdx == IDX_W'(i)) validQ[i] <= 1'b1;
        else if (killVec[i])                              validQ[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < TLB_ENTRIES; i++) begin
      if (strobe.fillEn && strobe.fillIdx == IDX_W'(i)) begin
        asidQ[i] <= fillAsid;
        vpnQ[i]  <= fillVpn;
        pfnQ[i]  <= fillPfn;
        attrQ[i] <= fillAttr;
      end
    end
  end

  // R4: an unfiltered flush-all with no fill leaves no valid line
  assert_flush_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.flushEn && strobe.flushType == FL_ALL && !strobe.flushAsidEn && !strobe.fillEn)
    |=> (validQ == '0));

  // R3: the line chosen for a fill is valid afterwards
  assert_fill_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.fillEn |=> validQ[$past(strobe.fillIdx)]);
endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int unsigned STAT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lkValid,
  input  logic        lookupHit,
  input  logic        fillValid,
  input  logic        regWe,
  input  logic [1:0]  regWrAddr,
  input  logic [31:0] regWrData,
  input  logic [1:0]  regRdAddr,
  output ctrlStrobe_t strobe,
  output logic        lkHit,
  output logic        lkMiss,
  output logic        lkStall,
  output logic [31:0] regRdData
);
  localparam logic [STAT_W-1:0]  STAT_MAX = '1;
  localparam logic [LINES_W-1:0] ENT_CNT  = LINES_W'(TLB_ENTRIES);

  logic [31:0]        tlbCfgQ;
  logic               statEnQ, statTestQ;
  logic               pendingQ;
  logic [IDX_W-1:0]   rrPtrQ;
  logic [STAT_W-1:0]  hitCntQ, missCntQ;

  logic               humOn;
  logic [LINES_W-1:0] activeEff;
  logic [IDX_W-1:0]   slotIdx, nextPtr;
  logic               wrTlbCfg, wrStatCfg, clrPulse;

  assign humOn     = tlbCfgQ[HUM_BIT];
  assign activeEff = (tlbCfgQ[LINES_W-1:0] > ENT_CNT) ? ENT_CNT : tlbCfgQ[LINES_W-1:0];
  assign slotIdx   = (LINES_W'(rrPtrQ) >= activeEff) ? '0 : rrPtrQ;
  assign nextPtr   = (LINES_W'(slotIdx) + LINES_W'(1) >= activeEff) ? '0 : slotIdx + IDX_W'(1);

  assign wrTlbCfg  = regWe && regWrAddr == WA_TLBCFG;
  assign wrStatCfg = regWe && regWrAddr == WA_STATCFG;
  assign clrPulse  = wrStatCfg && statTestQ && !regWrData[STAT_TEST_BIT];

  // lookup response
  assign lkHit   = lkValid && lookupHit && (!pendingQ || humOn);
  assign lkMiss  = lkValid && !lookupHit && !pendingQ;
  assign lkStall = lkValid && pendingQ && !(humOn && lookupHit);

  always_comb begin
    strobe.fillEn      = fillValid;
    strobe.fillIdx     = slotIdx;
    strobe.flushEn     = regWe && regWrAddr == WA_FLUSH;
    strobe.flushType   = regWrData[1:0];
    strobe.flushAsidEn = regWrData[FL_ASID_EN];
    strobe.flushAsid   = regWrData[FL_ASID_LSB +: ASID_W];
    strobe.flushVpn    = regWrData[VPN_W-1:GRP_LSB];
    strobe.activeLines = activeEff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tlbCfgQ   <= TLB_CFG_RST;
      statEnQ   <= 1'b0;
      statTestQ <= 1'b0;
      pendingQ  <= 1'b0;
      rrPtrQ    <= '0;
      hitCntQ   <= '0;
      missCntQ  <= '0;
    end else begin
      if (wrTlbCfg) tlbCfgQ <= regWrData;
      if (wrStatCfg) begin
        statEnQ   <= regWrData[STAT_EN_BIT];
        statTestQ <= regWrData[STAT_TEST_BIT];
      end
      if (lkMiss)         pendingQ <= 1'b1;
      else if (fillValid) pendingQ <= 1'b0;
      if (fillValid) rrPtrQ <= nextPtr;
      if (clrPulse) begin
        hitCntQ  <= '0;
        missCntQ <= '0;
      end else if (statEnQ) begin
        if (lkHit && hitCntQ != STAT_MAX)   hitCntQ  <= hitCntQ + STAT_W'(1);
        if (lkMiss && missCntQ != STAT_MAX) missCntQ <= missCntQ + STAT_W'(1);
      end
    end
  end

  always_comb begin
    case (regRdAddr)
      RA_HIT:    regRdData = 32'(hitCntQ);
      RA_MISS:   regRdData = 32'(missCntQ);
      RA_TLBCFG: regRdData = tlbCfgQ;
      default:   regRdData = {statEnQ, statTestQ, 30'd0};
    endcase
  end

  // R2: an outstanding miss persists until a fill
  assert_miss_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pendingQ && !fillValid) |=> pendingQ);

  // R9: no hit or miss is reported while blocked
  assert_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lkValid && pendingQ && !humOn) |-> (lkStall && !lkHit && !lkMiss));

  // R11: counters frozen while counting is off
  assert_cnt_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!statEnQ && !clrPulse) |=> ($stable(hitCntQ) && $stable(missCntQ)));

  // R12: a falling test bit clears both counters
  assert_cnt_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    clrPulse |=> (hitCntQ == '0 && missCntQ == '0));

  // R13: a full counter does not wrap
  assert_no_overflow_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (hitCntQ == STAT_MAX && !clrPulse) |=> (hitCntQ == STAT_MAX));
endmodule

// File: rtl/tlb_asid_cache.sv
module tlb_asid_cache
  import tlb_pkg::*;
#(
  parameter int unsigned STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lkValid,
  input  logic [ASID_W-1:0] lkAsid,
  input  logic [VPN_W-1:0]  lkVpn,
  output logic              lkHit,
  output logic              lkMiss,
  output logic              lkStall,
  output logic [PFN_W-1:0]  lkPfn,
  output logic              lkRd,
  output logic              lkWr,
  output logic              lkNs,
  input  logic              fillValid,
  input  logic [ASID_W-1:0] fillAsid,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [PFN_W-1:0]  fillPfn,
  input  logic              fillRd,
  input  logic              fillWr,
  input  logic              fillNs,
  input  logic              regWe,
  input  logic [1:0]        regWrAddr,
  input  logic [31:0]       regWrData,
  input  logic [1:0]        regRdAddr,
  output logic [31:0]       regRdData
);
  ctrlStrobe_t strobe;
  logic        lookupHit;
  pageAttr_t   hitAttr;
  pageAttr_t   fillAttr;

  assign fillAttr = '{rd: fillRd, wr: fillWr, ns: fillNs};
  assign lkRd     = hitAttr.rd;
  assign lkWr     = hitAttr.wr;
  assign lkNs     = hitAttr.ns;

  tlb_ctrl #(.STAT_W(STAT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .lkValid   (lkValid),
    .lookupHit (lookupHit),
    .fillValid (fillValid),
    .regWe     (regWe),
    .regWrAddr (regWrAddr),
    .regWrData (regWrData),
    .regRdAddr (regRdAddr),
    .strobe    (strobe),
    .lkHit     (lkHit),
    .lkMiss    (lkMiss),
    .lkStall   (lkStall),
    .regRdData (regRdData)
  );

  tlb_entry_array u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .fillAsid  (fillAsid),
    .fillVpn   (fillVpn),
    .fillPfn   (fillPfn),
    .fillAttr  (fillAttr),
    .lkAsid    (lkAsid),
    .lkVpn     (lkVpn),
    .lookupHit (lookupHit),
    .hitPfn    (lkPfn),
    .hitAttr   (hitAttr)
  );
endmodule

// File: tb/tlb_asid_cache_tb.sv
module tlb_asid_cache_tb;
  localparam int ENT = 16;
  localparam int SW  = 4;
  localparam int SMAX = (1 << SW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lkValid = 1'b0;
  logic [1:0] lkAsid = '0;
  logic [19:0] lkVpn = '0;
  logic lkHit, lkMiss, lkStall, lkRd, lkWr, lkNs;
  logic [19:0] lkPfn;
  logic fillValid = 1'b0;
  logic [1:0] fillAsid = '0;
  logic [19:0] fillVpn = '0, fillPfn = '0;
  logic fillRd = 1'b0, fillWr = 1'b0, fillNs = 1'b0;
  logic regWe = 1'b0;
  logic [1:0] regWrAddr = '0, regRdAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;

  tlb_asid_cache #(.STAT_W(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .lkValid(lkValid), .lkAsid(lkAsid), .lkVpn(lkVpn),
    .lkHit(lkHit), .lkMiss(lkMiss), .lkStall(lkStall), .lkPfn(lkPfn),
    .lkRd(lkRd), .lkWr(lkWr), .lkNs(lkNs), .fillValid(fillValid),
    .fillAsid(fillAsid), .fillVpn(fillVpn), .fillPfn(fillPfn),
    .fillRd(fillRd), .fillWr(fillWr), .fillNs(fillNs), .regWe(regWe),
    .regWrAddr(regWrAddr), .regWrData(regWrData), .regRdAddr(regRdAddr),
    .regRdData(regRdData)
  );

  always #2 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;

  // behavioural model
  bit         mVld  [ENT];
  logic [1:0] mAsid [ENT];
  logic [19:0] mVpn [ENT];
  logic [19:0] mPfn [ENT];
  logic [2:0] mAttr [ENT];
  int mPtr = 0, mAct = 16, mHitCnt = 0, mMissCnt = 0;
  bit mHum = 1, mPend = 0, mStatEn = 0, mTest = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int actEff();
    return (mAct > ENT) ? ENT : mAct;
  endfunction

  function automatic int mFind(logic [1:0] a, logic [19:0] v);
    for (int i = 0; i < ENT; i++)
      if (i < actEff() && mVld[i] && mAsid[i] == a && mVpn[i] == v) return i;
    return -1;
  endfunction

  function automatic void mFlush(logic [31:0] c);
    for (int i = 0; i < ENT; i++) begin
      bit aOk, vOk;
      aOk = !c[31] || (mAsid[i] == c[30:29]);
      case (c[1:0])
        2'd0: vOk = 1;
        2'd2: vOk = (mVpn[i][19:10] == c[19:10]);
        2'd3: vOk = (mVpn[i][19:2] == c[19:2]);
        default: vOk = 0;
      endcase
      if (aOk && vOk) mVld[i] = 0;
    end
  endfunction

  function automatic void mCount(int outcome);
    if (!mStatEn) return;
    if (outcome == 0 && mHitCnt < SMAX) mHitCnt++;
    if (outcome == 1 && mMissCnt < SMAX) mMissCnt++;
  endfunction

  function automatic int predict(logic [1:0] a, logic [19:0] v, output int idx);
    idx = mFind(a, v);
    if (mPend) return (mHum && idx >= 0) ? 0 : 2;
    return (idx >= 0) ? 0 : 1;
  endfunction

  task automatic checkResp(string tag, int exp, int idx);
    logic [2:0] ef;
    ef = (exp == 0) ? 3'b100 : (exp == 1) ? 3'b010 : 3'b001;
    chk({tag, " hit/miss/stall"}, {29'd0, lkHit, lkMiss, lkStall}, {29'd0, ef});
    if (exp == 0) begin
      chk({tag, " pfn"}, {12'd0, lkPfn}, {12'd0, mPfn[idx]});
      chk({tag, " attr"}, {29'd0, lkRd, lkWr, lkNs}, {29'd0, mAttr[idx]});
    end
  endtask

  task automatic lookup(string tag, logic [1:0] a, logic [19:0] v, output int outcome);
    int idx;
    outcome = predict(a, v, idx);
    @(negedge clk);
    lkValid = 1; lkAsid = a; lkVpn = v;
    #1 checkResp(tag, outcome, idx);
    @(posedge clk);
    mCount(outcome);
    if (outcome == 1) mPend = 1;
    #1 lkValid = 0;
  endtask

  task automatic fill(logic [1:0] a, logic [19:0] v, logic [19:0] p, logic [2:0] at);
    int idx;
    @(negedge clk);
    fillValid = 1; fillAsid = a; fillVpn = v; fillPfn = p; {fillRd, fillWr, fillNs} = at;
    @(posedge clk);
    idx = (mPtr >= actEff()) ? 0 : mPtr;
    mVld[idx] = 1; mAsid[idx] = a; mVpn[idx] = v; mPfn[idx] = p; mAttr[idx] = at;
    mPtr = (idx + 1 >= actEff()) ? 0 : idx + 1;
    mPend = 0;
    #1 fillValid = 0;
  endtask

  task automatic regWr(logic [1:0] ad, logic [31:0] d);
    @(negedge clk);
    regWe = 1; regWrAddr = ad; regWrData = d;
    @(posedge clk);
    case (ad)
      2'd0: mFlush(d);
      2'd1: begin mHum = d[29]; mAct = int'(d[4:0]); end
      2'd2: begin
        if (mTest && !d[30]) begin mHitCnt = 0; mMissCnt = 0; end
        mTest = d[30]; mStatEn = d[31];
      end
      default: ;
    endcase
    #1 regWe = 0;
  endtask

  task automatic regRd(logic [1:0] ad, output logic [31:0] d);
    @(negedge clk);
    regRdAddr = ad;
    #1 d = regRdData;
  endtask

  task automatic install(string tag, logic [1:0] a, logic [19:0] v, logic [19:0] p, logic [2:0] at);
    int o;
    lookup(tag, a, v, o);
    if (o == 1) fill(a, v, p, at);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #800000;
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    int o;
    logic [19:0] pool [8];
    pool = '{20'h00100, 20'h00101, 20'h00104, 20'h12345, 20'h12346, 20'h40000, 20'hFFFFF, 20'h00000};
    for (int i = 0; i < ENT; i++) mVld[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R14 reset state
    regRd(2'd2, rd); chk("R14 tlb cfg", rd, 32'h2000_0010);
    regRd(2'd0, rd); chk("R14 hit cnt", rd, 0);
    regRd(2'd1, rd); chk("R14 miss cnt", rd, 0);
    regRd(2'd3, rd); chk("R14 stat cfg", rd, 0);
    regWr(2'd2, 32'h8000_0000);

    // R1, R2 basic miss/fill/hit
    lookup("R14 empty lookup", 2'd1, 20'h00100, o);
    fill(2'd1, 20'h00100, 20'hABCDE, 3'b101);
    lookup("R1 hit", 2'd1, 20'h00100, o);
    chk("R1 outcome hit", o, 0);
    lookup("R2 asid mismatch", 2'd2, 20'h00100, o);
    chk("R2 outcome miss", o, 1);
    fill(2'd2, 20'h00100, 20'h11111, 3'b010);
    lookup("R2 visible after fill", 2'd2, 20'h00100, o);

    // R10 hit-under-miss on (reset value)
    lookup("R10 open miss", 2'd3, 20'h00200, o);
    lookup("R10 hit served", 2'd1, 20'h00100, o);
    lookup("R10 miss stalls", 2'd3, 20'h00300, o);
    chk("R10 stall outcome", o, 2);
    fill(2'd3, 20'h00200, 20'h22222, 3'b111);

    // R9 hit-under-miss off
    regWr(2'd1, 32'h0000_0010);
    lookup("R9 open miss", 2'd0, 20'h00400, o);
    lookup("R9 hit stalls", 2'd1, 20'h00100, o);
    chk("R9 stall outcome", o, 2);
    fill(2'd0, 20'h00400, 20'h33333, 3'b001);
    lookup("R9 hit after fill", 2'd1, 20'h00100, o);

    // R7 asid-qualified flush-all
    regWr(2'd0, 32'hC000_0000);
    lookup("R7 asid2 gone", 2'd2, 20'h00100, o);
    chk("R7 miss", o, 1);
    fill(2'd2, 20'h00100, 20'h11111, 3'b010);
    lookup("R7 asid1 kept", 2'd1, 20'h00100, o);
    chk("R7 hit", o, 0);

    // R4 flush all
    regWr(2'd0, 32'h0000_0000);
    lookup("R4 flushed", 2'd1, 20'h00100, o);
    chk("R4 miss", o, 1);
    fill(2'd1, 20'h00100, 20'hABCDE, 3'b101);

    // R5, R6 section and group flush
    install("R6 setup", 2'd1, 20'h12345, 20'h0A0A0, 3'b110);
    install("R6 setup", 2'd2, 20'h12346, 20'h0B0B0, 3'b100);
    install("R5 setup", 2'd1, 20'h12000, 20'h0C0C0, 3'b011);
    install("R5 setup", 2'd1, 20'h40000, 20'h0D0D0, 3'b111);
    regWr(2'd0, 32'h0001_2345);
    lookup("R6 type1 no effect", 2'd1, 20'h12345, o);
    chk("R6 type1 hit", o, 0);
    regWr(2'd0, 32'hA001_2347);
    lookup("R6 group killed", 2'd1, 20'h12345, o);
    chk("R6 group miss", o, 1);
    fill(2'd1, 20'h12345, 20'h0A0A0, 3'b110);
    lookup("R7 other asid in group", 2'd2, 20'h12346, o);
    chk("R7 group asid hit", o, 0);
    lookup("R6 outside group", 2'd1, 20'h12000, o);
    chk("R6 outside hit", o, 0);
    regWr(2'd0, 32'h0001_2002);
    lookup("R5 section killed", 2'd2, 20'h12346, o);
    chk("R5 miss", o, 1);
    fill(2'd2, 20'h12346, 20'h0B0B0, 3'b100);
    lookup("R5 other section", 2'd1, 20'h40000, o);
    chk("R5 other hit", o, 0);

    // R8 flush timing
    begin
      int idx, exp;
      exp = predict(2'd1, 20'h40000, idx);
      @(negedge clk);
      regWe = 1; regWrAddr = 2'd0; regWrData = 32'h0;
      lkValid = 1; lkAsid = 2'd1; lkVpn = 20'h40000;
      #1 checkResp("R8 same-cycle lookup", exp, idx);
      @(posedge clk);
      mCount(exp);
      mFlush(32'h0);
      #1 begin regWe = 0; lkValid = 0; end
      lookup("R8 after flush", 2'd1, 20'h40000, o);
      chk("R8 miss", o, 1);
      fill(2'd1, 20'h40000, 20'h0D0D0, 3'b111);
    end

    // R3 round-robin over 4 lines
    regWr(2'd0, 32'h0);
    regWr(2'd1, 32'h0000_0004);
    for (int k = 0; k < 5; k++) install("R3 fill", 2'd0, 20'h00500 + 20'(k), 20'h05000 + 20'(k), 3'b100);
    lookup("R3 oldest evicted", 2'd0, 20'h00500, o);
    chk("R3 evicted miss", o, 1);
    fill(2'd0, 20'h00500, 20'h05000, 3'b100);
    lookup("R3 kept", 2'd0, 20'h00503, o);
    chk("R3 kept hit", o, 0);

    // R1 lines above active count ignored
    regWr(2'd0, 32'h0);
    regWr(2'd1, 32'h0000_0010);
    for (int k = 0; k < 6; k++) install("R1 fill", 2'd3, 20'h00600 + 20'(k), 20'h06000 + 20'(k), 3'b010);
    regWr(2'd1, 32'h0000_0002);
    for (int k = 0; k < 6; k++) install("R1 active limit", 2'd3, 20'h00600 + 20'(k), 20'h06100 + 20'(k), 3'b001);

    // R12 clear pulse
    regWr(2'd2, 32'hC000_0000);
    regWr(2'd2, 32'h8000_0000);
    regRd(2'd0, rd); chk("R12 hit cleared", rd, 0);
    regRd(2'd1, rd); chk("R12 miss cleared", rd, 0);

    // R13 saturation
    regWr(2'd1, 32'h2000_0010);
    install("R13 setup", 2'd0, 20'h00700, 20'h07000, 3'b111);
    for (int k = 0; k < 20; k++) lookup("R13 hit", 2'd0, 20'h00700, o);
    regRd(2'd0, rd); chk("R13 saturated", rd, 32'(SMAX));

    // R11 counting disabled
    regWr(2'd2, 32'h4000_0000);
    regWr(2'd2, 32'h4000_0000);
    regWr(2'd2, 32'h0000_0000);
    lookup("R11 off hit", 2'd0, 20'h00700, o);
    install("R11 off miss", 2'd0, 20'h00777, 20'h07777, 3'b000);
    regRd(2'd0, rd); chk("R11 hit frozen", rd, 32'(mHitCnt));
    regRd(2'd1, rd); chk("R11 miss frozen", rd, 32'(mMissCnt));
    regWr(2'd2, 32'h8000_0000);

    // constrained random
    void'($urandom(32'd4242));
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom_range(0, 11));
      if (op == 0) begin
        logic [31:0] c;
        c = {1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), 9'd0,
             pool[$urandom_range(0, 7)][19:2], 2'($urandom_range(0, 3))};
        regWr(2'd0, c);
      end else if (op == 1) begin
        regWr(2'd1, {2'b00, 1'($urandom_range(0, 1)), 24'd0, 5'($urandom_range(1, 16))});
      end else begin
        install("R1 random", 2'($urandom_range(0, 3)), pool[$urandom_range(0, 7)],
                20'($urandom), 3'($urandom_range(0, 7)));
      end
    end
    regRd(2'd0, rd); chk("R11 random hit count", rd, 32'(mHitCnt));
    regRd(2'd1, rd); chk("R11 random miss count", rd, 32'(mMissCnt));

    finishRun();
  end
endmodule